// File: doc/BRIEF.md
# Inbound DMA Window Translator

This block maps the addresses of bus-master accesses arriving from a PCI bus onto local memory addresses. Three programmable windows are each described by a 64-bit size/attribute mask and a 64-bit local base. Every window starts at PCI address zero. A window whose enable bit is set claims the addresses below its size. A claimed address is moved up by that window's local base.

Software programs the windows through a 32-bit register slave with byte offsets. Writes take one clock edge. Reads are combinational from the offset. The translation path is purely combinational from the PCI address and the stored window state. It reports a hit flag, the index of the winning window and the resulting local address. The memory access itself is not part of this block.

Top module: `dma_inbound_xlat`

## Requirements
- R1: After reset every mask holds 0xFFFFFFFF_00000000, so its enable bit is clear. Every local base and the status word are zero, and no lookup hits. Mask readback: offset 0x98 returns 0x00000000 and offset 0xF8 returns 0xFFFFFFFF.
- R2: Bit 0 of a window's mask enables that window. A window with bit 0 clear never hits.
- R3: The window size is 2^64 minus the mask with bits 2:0 forced to zero, computed with 65-bit precision. A mask of 0x1 therefore covers the whole 64-bit space. Bits 2:1 of the mask do not affect the size. An address hits when it is below the size.
- R4: On a hit, `loc_addr` equals the winning window's local base plus `pci_addr`, modulo 2^64, and `win_idx` gives the window number (0, 1 or 2).
- R5: Window 1 has a single mask register at 0xA4. A write there loads the low 32 bits and clears the upper 32 bits. A read of 0xA4 returns the low 32 bits.
- R6: Each 64-bit field is written in halves, and writing one half leaves the other half unchanged. The offsets are as follows. Window 0: mask low 0x98, mask high 0xF8, base low 0x9C, base high 0xA0. Window 1: base low 0xA8, base high 0xAC. Window 2: mask low 0xB0, mask high 0xFC, base low 0xB4, base high 0xB8. Every half reads back what was written.
- R7: A register write sampled at a clock edge is reflected in the lookup outputs as soon as that edge has passed.
- R8: When several windows hit, the lowest index wins.
- R9: On a miss, `hit` is 0, `win_idx` is 0 and `loc_addr` equals `pci_addr`.
- R10: Offset 0xE0 is a 32-bit status word that can be read and written, with no side effects.
- R11: Offsets not listed above read as zero. Writes to them change no register and no lookup result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| pci_addr | input | 64 | Inbound PCI address |
| loc_addr | output | 64 | Translated local address |
| hit | output | 1 | Address falls in an enabled window |
| win_idx | output | 2 | Index of the winning window |

## Verification
The assertions check the following on every cycle:
- the miss pass-through;
- that no hit is reported while all enable bits are clear;
- that the lowest-index window wins among those that match;
- that a write to the window 1 mask clears its upper half;
- that a low-half write keeps the window 0 upper mask;
- that the status word stores its write data.

The bench scenarios show the rest:
- the exact size boundary at size-1 and at size;
- that mask bits 2:1 are ignored;
- the full-space window;
- base addition that wraps past 2^64;
- readback of every half;
- writes to unmapped offsets.

These are compared against a model of the register state kept in the bench, under random window shapes and random addresses.

// File: rtl/dma_inbound_xlat.sv
module dma_inbound_xlat (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [7:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic [63:0] pci_addr,
  output logic [63:0] loc_addr,
  output logic        hit,
  output logic [1:0]  win_idx
);
  localparam int NWIN = 3;
  localparam logic [63:0] MASK_RST = 64'hFFFF_FFFF_0000_0000;
  localparam logic [64:0] SPACE    = 65'h1_0000_0000_0000_0000;

  logic [63:0] msk [NWIN];
  logic [63:0] bas [NWIN];
  logic [31:0] sts;
  logic [64:0] wsize [NWIN];
  logic [NWIN-1:0] in_win;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NWIN; i++) begin
        msk[i] <= MASK_RST;
        bas[i] <= '0;
      end
      sts <= '0;
    end else if (reg_wr) begin
      case (reg_addr)
        8'h98: msk[0][31:0]  <= reg_wdata;
        8'hF8: msk[0][63:32] <= reg_wdata;
        8'h9C: bas[0][31:0]  <= reg_wdata;
        8'hA0: bas[0][63:32] <= reg_wdata;
        8'hA4: msk[1]        <= {32'h0, reg_wdata};
        8'hA8: bas[1][31:0]  <= reg_wdata;
        8'hAC: bas[1][63:32] <= reg_wdata;
        8'hB0: msk[2][31:0]  <= reg_wdata;
        8'hFC: msk[2][63:32] <= reg_wdata;
        8'hB4: bas[2][31:0]  <= reg_wdata;
        8'hB8: bas[2][63:32] <= reg_wdata;
        8'hE0: sts           <= reg_wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (reg_addr)
      8'h98:   reg_rdata = msk[0][31:0];
      8'hF8:   reg_rdata = msk[0][63:32];
      8'h9C:   reg_rdata = bas[0][31:0];
      8'hA0:   reg_rdata = bas[0][63:32];
      8'hA4:   reg_rdata = msk[1][31:0];
      8'hA8:   reg_rdata = bas[1][31:0];
      8'hAC:   reg_rdata = bas[1][63:32];
      8'hB0:   reg_rdata = msk[2][31:0];
      8'hFC:   reg_rdata = msk[2][63:32];
      8'hB4:   reg_rdata = bas[2][31:0];
      8'hB8:   reg_rdata = bas[2][63:32];
      8'hE0:   reg_rdata = sts;
      default: reg_rdata = '0;
    endcase
  end

  for (genvar g = 0; g < NWIN; g++) begin : g_win
    assign wsize[g]  = SPACE - {1'b0, msk[g] & ~64'h7};
    assign in_win[g] = msk[g][0] && ({1'b0, pci_addr} < wsize[g]);
  end

  always_comb begin
    hit      = 1'b0;
    win_idx  = 2'd0;
    loc_addr = pci_addr;
    for (int i = NWIN - 1; i >= 0; i--) begin
      if (in_win[i]) begin
        hit      = 1'b1;
        win_idx  = 2'(i);
        loc_addr = pci_addr + bas[i];
      end
    end
  end

  p_miss_passthru_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> (loc_addr == pci_addr && win_idx == 2'd0));

  p_disabled_nohit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!msk[0][0] && !msk[1][0] && !msk[2][0]) |-> !hit);

  p_lowest_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> ((in_win & ((3'b001 << win_idx) - 3'b001)) == 3'b000));

  p_win1_upper_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 8'hA4) |=> (msk[1][63:32] == 32'h0));

  p_half_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 8'h98) |=> $stable(msk[0][63:32]));

  p_status_store_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 8'hE0) |=> (sts == $past(reg_wdata)));
endmodule

// File: tb/test_dma_inbound_xlat.sv
`timescale 1ns/100ps
module test_dma_inbound_xlat;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [63:0] pci_addr = '0;
  logic [63:0] loc_addr;
  logic        hit;
  logic [1:0]  win_idx;

  int vecs = 0;
  int errs = 0;
  logic [63:0] m_msk [3];
  logic [63:0] m_bas [3];
  logic [31:0] m_sts;

  always #2.5 clk = ~clk;

  dma_inbound_xlat i_dma_inbound_xlat (.*);

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 3; i++) begin
      m_msk[i] = 64'hFFFF_FFFF_0000_0000;
      m_bas[i] = '0;
    end
    m_sts = '0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
    case (a)
      8'h98: m_msk[0][31:0]  = d;
      8'hF8: m_msk[0][63:32] = d;
      8'h9C: m_bas[0][31:0]  = d;
      8'hA0: m_bas[0][63:32] = d;
      8'hA4: m_msk[1]        = {32'h0, d};
      8'hA8: m_bas[1][31:0]  = d;
      8'hAC: m_bas[1][63:32] = d;
      8'hB0: m_msk[2][31:0]  = d;
      8'hFC: m_msk[2][63:32] = d;
      8'hB4: m_bas[2][31:0]  = d;
      8'hB8: m_bas[2][63:32] = d;
      8'hE0: m_sts           = d;
      default: ;
    endcase
  endtask

  function automatic logic [31:0] exp_rd(input logic [7:0] a);
    case (a)
      8'h98: return m_msk[0][31:0];
      8'hF8: return m_msk[0][63:32];
      8'h9C: return m_bas[0][31:0];
      8'hA0: return m_bas[0][63:32];
      8'hA4: return m_msk[1][31:0];
      8'hA8: return m_bas[1][31:0];
      8'hAC: return m_bas[1][63:32];
      8'hB0: return m_msk[2][31:0];
      8'hFC: return m_msk[2][63:32];
      8'hB4: return m_bas[2][31:0];
      8'hB8: return m_bas[2][63:32];
      8'hE0: return m_sts;
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [66:0] exp_lk(input logic [63:0] a);
    for (int i = 0; i < 3; i++) begin
      logic [64:0] sz;
      sz = 65'h1_0000_0000_0000_0000 - {1'b0, m_msk[i] & ~64'h7};
      if (m_msk[i][0] && ({1'b0, a} < sz))
        return {1'b1, 2'(i), a + m_bas[i]};
    end
    return {1'b0, 2'd0, a};
  endfunction

  task automatic rd(input string tag, input logic [7:0] a);
    @(negedge clk);
    reg_addr = a;
    #1;
    chk(tag, {32'h0, reg_rdata}, {32'h0, exp_rd(a)});
  endtask

  task automatic lk(input string tag, input logic [63:0] a);
    logic [66:0] e;
    @(negedge clk);
    pci_addr = a;
    #1;
    e = exp_lk(a);
    chk({tag, " hit"}, {63'h0, hit}, {63'h0, e[66]});
    chk({tag, " idx"}, {62'h0, win_idx}, {62'h0, e[65:64]});
    chk({tag, " loc"}, loc_addr, e[63:0]);
  endtask

  function automatic logic [63:0] r64();
    return {$urandom(), $urandom()};
  endfunction

  initial begin
    #(200000 * 5);
    errs++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    logic [7:0] offs [13];
    offs = '{8'h98, 8'hF8, 8'h9C, 8'hA0, 8'hA4, 8'hA8, 8'hAC,
             8'hB0, 8'hFC, 8'hB4, 8'hB8, 8'hE0, 8'h40};
    void'($urandom(32'd1234));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd("R1 mask0 lo", 8'h98);
    rd("R1 mask0 hi", 8'hF8);
    rd("R1 base2 lo", 8'hB4);
    rd("R1 status", 8'hE0);
    lk("R1 no hit", 64'h0);
    lk("R9 miss passthru", 64'h1234_5678_9ABC_DEF0);

    // R2 enable bit
    wr(8'hF8, 32'hFFFF_FFFF); wr(8'h98, 32'hFFF0_0000);
    lk("R2 disabled", 64'h10);
    // R7 write visible next lookup
    wr(8'h98, 32'hFFF0_0001);
    lk("R7 after enable", 64'h10);
    // R3 boundary
    lk("R3 size-1", 64'h000F_FFFF);
    lk("R3 size", 64'h0010_0000);
    wr(8'h98, 32'hFFF0_0007);
    lk("R3 low bits ignored in", 64'h000F_FFFF);
    lk("R3 low bits ignored out", 64'h0010_0000);
    // R4 base with wrap
    wr(8'h9C, 32'hFFFF_FFF0); wr(8'hA0, 32'hFFFF_FFFF);
    lk("R4 wrap", 64'h20);
    // R6 half preserve
    rd("R6 mask0 hi kept", 8'hF8);
    rd("R6 base0 lo", 8'h9C);
    // R5 window 1 single register
    wr(8'hA4, 32'h0000_0001);
    rd("R5 mask1 read", 8'hA4);
    lk("R5 upper cleared full", 64'hFFFF_0000_0000_0000);
    // R8 priority: window 0 and 1 overlap
    wr(8'hA8, 32'h1000);
    lk("R8 win0 over win1", 64'h40);
    lk("R8 win1 beyond win0", 64'h0100_0000);
    // R3 full space on window 2, window 0/1 disabled
    wr(8'h98, 32'h0); wr(8'hA4, 32'h0);
    wr(8'hFC, 32'h0); wr(8'hB0, 32'h1);
    lk("R3 full space", 64'hFFFF_FFFF_FFFF_FFFF);
    // R10 status
    wr(8'hE0, 32'hA5A5_5A5A);
    rd("R10 status", 8'hE0);
    // R11 unmapped
    wr(8'h40, 32'hFFFF_FFFF);
    rd("R11 unmapped", 8'h40);
    rd("R11 status untouched", 8'hE0);
    lk("R11 lookup unchanged", 64'h77);

    // random mix
    for (int it = 0; it < 400; it++) begin
      int op;
      op = $urandom_range(0, 9);
      if (op < 3) begin
        int w;
        int k;
        logic [63:0] m;
        w = $urandom_range(0, 2);
        k = $urandom_range(8, 48);
        m = ~((64'h1 << k) - 64'h1) | 64'($urandom_range(0, 7));
        if ($urandom_range(0, 5) == 0) m = r64();
        if (w == 0) begin wr(8'h98, m[31:0]); wr(8'hF8, m[63:32]); end
        else if (w == 1) wr(8'hA4, m[31:0]);
        else begin wr(8'hB0, m[31:0]); wr(8'hFC, m[63:32]); end
        if ($urandom_range(0, 1) == 1) begin
          logic [63:0] b;
          b = r64();
          wr(w == 0 ? 8'h9C : (w == 1 ? 8'hA8 : 8'hB4), b[31:0]);
          wr(w == 0 ? 8'hA0 : (w == 1 ? 8'hAC : 8'hB8), b[63:32]);
        end
      end else if (op < 4) begin
        logic [7:0] a;
        a = offs[$urandom_range(0, 12)];
        if ($urandom_range(0, 2) == 0) wr(a, $urandom());
        rd("R6 R11 random readback", a);
      end else begin
        logic [63:0] a;
        a = r64();
        if ($urandom_range(0, 1) == 1) a = a >> $urandom_range(8, 60);
        lk("R4 R8 random lookup", a);
      end
    end

    $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule